// File: doc/BRIEF.md
# Supply and Temperature Safety Supervisor

This block guards a safety controller against a bad supply rail and against overheating. Each clock it looks at a digitized supply sample in millivolts and a signed internal temperature sample in whole degrees Celsius. It compares both samples with an under-voltage limit, an over-voltage limit and a fixed thermal limit. Each kind of fault has its own persistence counter, which advances on a 1 ms tick. When one of these counters reaches the configured persistence value, the block forces a latched safe state.

Once the block is in safe state, it holds an all-outputs-off request and reports a unique cause code. Only a reset clears that state. The block also checks its own limit configuration on every cycle, and it latches safe state at once if the configuration is not usable. Drivers further down the chip treat the off request as an order to de-energize every output.

Top module: `supply_guard`

## Requirements
- R1: While reset is high, and on the first cycle after it, `safe_o` and `off_req_o` are 0 and `cause_o` is 0 (none).
- R2: If the supply sample stays below `cfg_uv_mv` for P consecutive ticks, safe state is entered on the edge that samples the P-th tick, with cause 1 (under-voltage).
- R3: If the supply sample stays above `cfg_ov_mv` for P consecutive ticks, safe state is entered on the P-th tick, with cause 2 (over-voltage).
- R4: If the supply sample is outside the window for P consecutive ticks, without staying on one side for P ticks, safe state is entered with cause 3 (unstable). When several faults reach P on the same tick, the cause is chosen in this order: configuration, under-voltage, over-voltage, unstable, thermal.
- R5: If the temperature stays above 85 °C for P consecutive ticks, safe state is entered with cause 4 (over-temperature). A temperature of exactly 85 °C is not a fault.
- R6: Each persistence counter clears on any cycle in which its own fault condition is absent, so the full P ticks must run again before a trip.
- R7: P equals `cfg_persist` clamped to the range 500 to 1000. A value below 500 acts as 500, and a value above 1000 acts as 1000.
- R8: If `cfg_uv_mv` lies outside 7000 to 30000, or `cfg_ov_mv` lies outside 8000 to 33000, or `cfg_uv_mv` is not below `cfg_ov_mv`, safe state is entered on the next clock edge with cause 5 (configuration), whether or not a tick is present.
- R9: Once safe state is entered, `safe_o` stays 1 and `cause_o` keeps its value until reset, even after every sample returns to normal.
- R10: `off_req_o` is 1 on every cycle in which `safe_o` is 1. Apart from a configuration trip, safe state is only entered on a cycle that carries a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, the only way to leave safe state |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| supply_mv_i | input | VW (16) | Supply sample in millivolts |
| temp_c_i | input | TW (10) | Signed temperature sample in degrees Celsius |
| cfg_uv_mv | input | VW (16) | Under-voltage limit in millivolts |
| cfg_ov_mv | input | VW (16) | Over-voltage limit in millivolts |
| cfg_persist | input | PW (11) | Persistence count in ticks, before clamping |
| safe_o | output | 1 | Latched safe-state flag |
| off_req_o | output | 1 | Request to turn every output off |
| cause_o | output | 3 | Cause code: 0 none, 1 under-voltage, 2 over-voltage, 3 unstable, 4 over-temperature, 5 configuration |

## Verification
A counter that clears at the wrong moment, or trips one count off, shows at the ports as a safe flag that rises one tick too early or too late, or never rises at all. For that reason the bench samples the flag both on the tick just before P and on the P-th tick. A wrong priority or a wrong cause encoding appears in `cause_o` on the same cycle that `safe_o` rises. A latch that leaks shows on the first normal tick after the trip, and the bench then runs dozens of normal ticks to catch it.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [2:0] {
    CZ_NONE     = 3'd0,
    CZ_UNDER    = 3'd1,
    CZ_OVER     = 3'd2,
    CZ_UNSTABLE = 3'd3,
    CZ_HOT      = 3'd4,
    CZ_CONFIG   = 3'd5
  } cause_e;

  // fault vector index order, also the trip priority (lower index wins)
  localparam int F_UNDER    = 0;
  localparam int F_OVER     = 1;
  localparam int F_UNSTABLE = 2;
  localparam int F_HOT      = 3;
  localparam int NFLT       = 4;
endpackage

// File: rtl/sg_window.sv
module sg_window #(
  parameter int VW       = 16,
  parameter int TW       = 10,
  parameter int TEMP_LIM = 85,
  parameter int UV_MIN   = 7000,
  parameter int UV_MAX   = 30000,
  parameter int OV_MIN   = 8000,
  parameter int OV_MAX   = 33000
) (
  input  logic                 [VW-1:0] mv,
  input  logic signed          [TW-1:0] temp,
  input  logic                 [VW-1:0] uv_lim,
  input  logic                 [VW-1:0] ov_lim,
  output logic [sg_pkg::NFLT-1:0]       flt,
  output logic                          cfg_bad
);
  import sg_pkg::*;
  localparam logic        [VW-1:0] UVMN = VW'(UV_MIN);
  localparam logic        [VW-1:0] UVMX = VW'(UV_MAX);
  localparam logic        [VW-1:0] OVMN = VW'(OV_MIN);
  localparam logic        [VW-1:0] OVMX = VW'(OV_MAX);
  localparam logic signed [TW-1:0] HOT  = TW'(TEMP_LIM);

  logic below, above;

  always_comb begin
    below             = mv < uv_lim;
    above             = mv > ov_lim;
    flt[F_UNDER]      = below;
    flt[F_OVER]       = above;
    flt[F_UNSTABLE]   = below | above;
    flt[F_HOT]        = temp > HOT;
    cfg_bad = (uv_lim < UVMN) || (uv_lim > UVMX) ||
              (ov_lim < OVMN) || (ov_lim > OVMX) ||
              (uv_lim >= ov_lim);
  end
endmodule

// File: rtl/sg_persist.sv
module sg_persist #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          flt,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  logic [CW-1:0] cnt;
  logic [CW:0]   nxt;

  always_comb begin
    nxt = {1'b0, cnt} + 1'b1;
    hit = flt && tick && (nxt >= {1'b0, limit});
  end

  always_ff @(posedge clk) begin
    if (rst || !flt)
      cnt <= '0;
    else if (tick && (cnt < limit))
      cnt <= nxt[CW-1:0];
  end
endmodule

// File: rtl/sg_latch.sv
module sg_latch (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_bad,
  input  logic [sg_pkg::NFLT-1:0] hit,
  output logic                    safe,
  output logic                    off_req,
  output logic [2:0]              cause
);
  import sg_pkg::*;
  cause_e pick;

  always_comb begin
    if (cfg_bad)                pick = CZ_CONFIG;
    else if (hit[F_UNDER])      pick = CZ_UNDER;
    else if (hit[F_OVER])       pick = CZ_OVER;
    else if (hit[F_UNSTABLE])   pick = CZ_UNSTABLE;
    else if (hit[F_HOT])        pick = CZ_HOT;
    else                        pick = CZ_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      safe    <= 1'b0;
      off_req <= 1'b0;
      cause   <= CZ_NONE;
    end else if (!safe && (pick != CZ_NONE)) begin
      safe    <= 1'b1;
      off_req <= 1'b1;
      cause   <= pick;
    end
  end
endmodule

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int VW       = 16,
  parameter int TW       = 10,
  parameter int PW       = 11,
  parameter int PMIN     = 500,
  parameter int PMAX     = 1000,
  parameter int TEMP_LIM = 85,
  parameter int UV_MIN   = 7000,
  parameter int UV_MAX   = 30000,
  parameter int OV_MIN   = 8000,
  parameter int OV_MAX   = 33000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic [VW-1:0]        supply_mv_i,
  input  logic signed [TW-1:0] temp_c_i,
  input  logic [VW-1:0]        cfg_uv_mv,
  input  logic [VW-1:0]        cfg_ov_mv,
  input  logic [PW-1:0]        cfg_persist,
  output logic                 safe_o,
  output logic                 off_req_o,
  output logic [2:0]           cause_o
);
  import sg_pkg::*;
  localparam int CW = $clog2(PMAX + 1);
  localparam logic [PW-1:0] PLO = PW'(PMIN);
  localparam logic [PW-1:0] PHI = PW'(PMAX);

  logic [NFLT-1:0] flt, hit;
  logic            cfg_bad;
  logic [PW-1:0]   lim_w;
  logic [CW-1:0]   lim;

  always_comb begin
    if (cfg_persist < PLO)      lim_w = PLO;
    else if (cfg_persist > PHI) lim_w = PHI;
    else                        lim_w = cfg_persist;
    lim = lim_w[CW-1:0];
  end

  sg_window #(
    .VW(VW), .TW(TW), .TEMP_LIM(TEMP_LIM),
    .UV_MIN(UV_MIN), .UV_MAX(UV_MAX), .OV_MIN(OV_MIN), .OV_MAX(OV_MAX)
  ) u_win (
    .mv(supply_mv_i), .temp(temp_c_i), .uv_lim(cfg_uv_mv), .ov_lim(cfg_ov_mv),
    .flt(flt), .cfg_bad(cfg_bad)
  );

  for (genvar g = 0; g < NFLT; g++) begin : g_cnt
    sg_persist #(.CW(CW)) u_cnt (
      .clk(clk), .rst(rst), .tick(tick_i), .flt(flt[g]), .limit(lim), .hit(hit[g])
    );
  end

  sg_latch u_latch (
    .clk(clk), .rst(rst), .cfg_bad(cfg_bad), .hit(hit),
    .safe(safe_o), .off_req(off_req_o), .cause(cause_o)
  );
endmodule

// File: rtl/sg_chk.sv
module sg_chk #(
  parameter int VW     = 16,
  parameter int UV_MIN = 7000,
  parameter int UV_MAX = 30000,
  parameter int OV_MIN = 8000,
  parameter int OV_MAX = 33000
) (
  input logic          clk,
  input logic          rst,
  input logic          tick_i,
  input logic [VW-1:0] cfg_uv_mv,
  input logic [VW-1:0] cfg_ov_mv,
  input logic          safe_o,
  input logic          off_req_o,
  input logic [2:0]    cause_o
);
  logic bad_cfg;
  always_comb
    bad_cfg = (32'(cfg_uv_mv) < UV_MIN) || (32'(cfg_uv_mv) > UV_MAX) ||
              (32'(cfg_ov_mv) < OV_MIN) || (32'(cfg_ov_mv) > OV_MAX) ||
              (cfg_uv_mv >= cfg_ov_mv);

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    safe_o |=> safe_o);
  // R9
  cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    safe_o |=> $stable(cause_o));
  // R10
  off_req_chk: assert property (@(posedge clk) disable iff (rst)
    safe_o |-> off_req_o);
  // R1
  idle_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !safe_o |-> (cause_o == 3'd0));
  // R8
  cfg_trip_chk: assert property (@(posedge clk) disable iff (rst)
    bad_cfg |=> safe_o);
  // R10
  tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(safe_o) && (cause_o != 3'd5)) |-> $past(tick_i));
  // R4
  cause_range_chk: assert property (@(posedge clk) disable iff (rst)
    safe_o |-> (cause_o >= 3'd1 && cause_o <= 3'd5));
endmodule

bind supply_guard sg_chk #(
  .VW(VW), .UV_MIN(UV_MIN), .UV_MAX(UV_MAX), .OV_MIN(OV_MIN), .OV_MAX(OV_MAX)
) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .cfg_uv_mv(cfg_uv_mv), .cfg_ov_mv(cfg_ov_mv),
  .safe_o(safe_o), .off_req_o(off_req_o), .cause_o(cause_o)
);

// File: tb/sim_supply_guard.sv
`timescale 1ns/1ps
module sim_supply_guard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [15:0] mv = 16'd24000;
  logic signed [9:0] temp = 10'sd40;
  logic [15:0] uv = 16'd10000;
  logic [15:0] ov = 16'd28000;
  logic [10:0] pers = 11'd500;
  logic safe, offr;
  logic [2:0] cause;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  supply_guard u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .supply_mv_i(mv), .temp_c_i(temp),
    .cfg_uv_mv(uv), .cfg_ov_mv(ov), .cfg_persist(pers),
    .safe_o(safe), .off_req_o(offr), .cause_o(cause)
  );

  function automatic int eff_p(int p);
    if (p < 500) return 500;
    if (p > 1000) return 1000;
    return p;
  endfunction

  task automatic chk(string req, bit es, int ec);
    total++;
    if (safe !== es || offr !== es || cause !== 3'(ec)) begin
      bad++;
      $display("FAIL %s: safe=%0b off=%0b cause=%0d expected safe=%0b off=%0b cause=%0d",
               req, safe, offr, cause, es, es, ec);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; mv = 16'd24000; temp = 10'sd40;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // kind 0 under, 1 over, 2 alternating, 3 hot, 4 normal
  task automatic ticks(int kind, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (kind)
        0: begin mv = 16'(int'(uv) - 1 - int'($urandom % 3000)); temp = 10'sd40; end
        1: begin mv = 16'(int'(ov) + 1 + int'($urandom % 3000)); temp = 10'sd40; end
        2: begin mv = (i % 2 == 0) ? 16'd5000 : 16'd31000; temp = 10'sd40; end
        3: begin mv = 16'd24000; temp = 10'(86 + int'($urandom % 40)); end
        default: begin mv = 16'(12000 + int'($urandom % 15000)); temp = 10'sd40; end
      endcase
      tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1 reset and first cycle after
    chk("R1", 0, 0);
    @(negedge clk); chk("R1", 0, 0);

    // R2 under-voltage exactly at P
    ticks(0, 499); chk("R2", 0, 0);
    ticks(0, 1);   chk("R2", 1, 1);
    // R9 latch holds after recovery
    ticks(4, 40);  chk("R9", 1, 1);
    do_reset();    chk("R9", 0, 0);

    // R3 over-voltage
    ticks(1, 499); chk("R3", 0, 0);
    ticks(1, 1);   chk("R3", 1, 2);
    do_reset();

    // R4 alternating sides
    ticks(2, 499); chk("R4", 0, 0);
    ticks(2, 1);   chk("R4", 1, 3);
    do_reset();

    // R5 exactly 85 is no fault, above trips
    @(negedge clk); temp = 10'sd85;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
    chk("R5", 0, 0);
    ticks(3, 500); chk("R5", 1, 4);
    do_reset();

    // R6 a single good tick restarts the count
    ticks(0, 300); ticks(4, 1); ticks(0, 499); chk("R6", 0, 0);
    ticks(0, 1);   chk("R6", 1, 1);
    do_reset();

    // R7 clamp below and above
    pers = 11'd100;
    ticks(1, 499); chk("R7", 0, 0);
    ticks(1, 1);   chk("R7", 1, 2);
    do_reset();
    pers = 11'd2000;
    ticks(3, 999); chk("R7", 0, 0);
    ticks(3, 1);   chk("R7", 1, 4);
    do_reset();
    pers = 11'd500;

    // R8 limits inverted, no tick needed
    @(negedge clk); uv = 16'd20000; ov = 16'd20000;
    @(negedge clk); chk("R8", 1, 5);
    uv = 16'd10000; ov = 16'd28000;
    do_reset();
    @(negedge clk); ov = 16'd34000;
    @(negedge clk); chk("R8", 1, 5);
    ov = 16'd28000;
    do_reset();
    @(negedge clk); uv = 16'd6999;
    @(negedge clk); chk("R8", 1, 5);
    uv = 16'd10000;
    do_reset(); chk("R8", 0, 0);

    // R10 no tick, no trip, even with a bad sample
    @(negedge clk); mv = 16'd3000;
    repeat (1200) @(negedge clk);
    chk("R10", 0, 0);
    do_reset();

    // random persistence and fault kind
    for (int r = 0; r < 12; r++) begin
      int p, k, ec;
      p = 400 + int'($urandom % 700);
      k = int'($urandom % 4);
      uv = 16'(9000 + int'($urandom % 3000));
      ov = 16'(25000 + int'($urandom % 4000));
      pers = 11'(p);
      do_reset();
      ec = k + 1;
      ticks(k, eff_p(p) - 1); chk("R7", 0, 0);
      ticks(k, 1);            chk(k == 0 ? "R2" : k == 1 ? "R3" : k == 2 ? "R4" : "R5", 1, ec);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule